// File: doc/BRIEF.md
# Dual-Issue Interlock and Forwarding Control

This block decides issue for a two-wide, five-stage in-order core. Each cycle it receives the pair of decoded instructions waiting to issue: slot A, the older one, and slot B, the younger one. It also receives the destination registers held by the execute, memory and writeback stages of both pipelines. For every source operand of the pair it finds the youngest in-flight producer and emits a select code for the operand forwarding multiplexer. That producer can be in the same pipeline or in the other one.

The block then chooses one of three outcomes: both instructions issue, only A issues, or the pair stalls. A pair stalls when an operand would need a load result that is still in execute. B is held back when it reads A's destination, or when both instructions access memory. All decisions and select codes are registered, so they appear one clock after the inputs that caused them.

Top module: `dual_issue_interlock`

## Requirements
- R1: Each operand select names the youngest matching producer. Execute is youngest, then memory, then writeback. Within one stage, pipeline B is preferred over pipeline A. The codes are 0 register file, 1 execute A, 2 execute B, 3 memory A, 4 memory B, 5 writeback A and 6 writeback B.
- R2: A source with its enable low, or with no matching producer, selects code 0. A producer with its write enable low never matches.
- R3: Register 0 is compared and forwarded like any other register number.
- R4: If the winning producer of any enabled source of a valid slot is an execute-stage load, stall_o is high and neither slot issues. Slot B's sources count only when B is valid.
- R5: If valid B has an enabled source equal to the rd of valid A, and A's write enable is set, pair_dep_o is high and B does not issue.
- R6: If A and B are both valid and both memory operations, struct_hazard_o is high and B does not issue.
- R7: issue_b_o is high only when issue_a_o is high. An invalid B never issues.
- R8: A valid A issues exactly when there is no load stall. An invalid A issues nothing and raises no hazard flag.
- R9: All outputs are registered with a one-cycle latency. While rst_ni is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_valid_i | input | 1 | Slot A holds an instruction |
| a_rs1_i | input | 5 | Slot A first source register |
| a_rs1_en_i | input | 1 | Slot A first source is read |
| a_rs2_i | input | 5 | Slot A second source register |
| a_rs2_en_i | input | 1 | Slot A second source is read |
| a_rd_i | input | 5 | Slot A destination register |
| a_we_i | input | 1 | Slot A writes rd |
| a_mem_i | input | 1 | Slot A is a load or store |
| b_valid_i | input | 1 | Slot B holds an instruction |
| b_rs1_i | input | 5 | Slot B first source register |
| b_rs1_en_i | input | 1 | Slot B first source is read |
| b_rs2_i | input | 5 | Slot B second source register |
| b_rs2_en_i | input | 1 | Slot B second source is read |
| b_rd_i | input | 5 | Slot B destination register |
| b_we_i | input | 1 | Slot B writes rd |
| b_mem_i | input | 1 | Slot B is a load or store |
| ex_a_we_i | input | 1 | Execute A writes a register |
| ex_a_rd_i | input | 5 | Execute A destination |
| ex_a_load_i | input | 1 | Execute A is a load |
| ex_b_we_i | input | 1 | Execute B writes a register |
| ex_b_rd_i | input | 5 | Execute B destination |
| ex_b_load_i | input | 1 | Execute B is a load |
| mem_a_we_i | input | 1 | Memory A writes a register |
| mem_a_rd_i | input | 5 | Memory A destination |
| mem_b_we_i | input | 1 | Memory B writes a register |
| mem_b_rd_i | input | 5 | Memory B destination |
| wb_a_we_i | input | 1 | Writeback A writes a register |
| wb_a_rd_i | input | 5 | Writeback A destination |
| wb_b_we_i | input | 1 | Writeback B writes a register |
| wb_b_rd_i | input | 5 | Writeback B destination |
| issue_a_o | output | 1 | Slot A issues |
| issue_b_o | output | 1 | Slot B issues |
| stall_o | output | 1 | Pair stalled on a load result |
| struct_hazard_o | output | 1 | Both slots are memory operations |
| pair_dep_o | output | 1 | B reads A's destination |
| fwd_a1_o | output | 3 | Select for slot A first source |
| fwd_a2_o | output | 3 | Select for slot A second source |
| fwd_b1_o | output | 3 | Select for slot B first source |
| fwd_b2_o | output | 3 | Select for slot B second source |

## Verification
Several of the block's functions can act in the same cycle, and their outcomes combine.

A pair dependency and a memory conflict can both hold B back while A still issues. A load stall can hit in a cycle where B also depends on A, and then it suppresses both slots.

These overlaps are forced by directed vectors and also arise often in random traffic. The random stimulus draws registers from only four numbers, so matches are frequent. A bench model evaluates the hazard flags independently and then composes the issue outcome. Each flag and each issue bit is compared one cycle after its inputs.

// File: rtl/dii_pkg.sv
package dii_pkg;
  typedef enum logic [1:0] {
    ISSUE_NONE = 2'd0,
    ISSUE_A    = 2'd1,
    ISSUE_BOTH = 2'd2
  } issue_e;

  // producer index p in stage s maps to select code 1 + 2*s + p (0 = register file)
  function automatic int unsigned fwd_code(int unsigned stage, int unsigned pipe);
    return 1 + 2 * stage + pipe;
  endfunction
endpackage

// File: rtl/dii_fwd_select.sv
module dii_fwd_select #(
  parameter int unsigned REG_W   = 5,
  parameter int unsigned NSTAGES = 3,
  parameter int unsigned SEL_W   = 3
) (
  input  logic                         src_en_i,
  input  logic [REG_W-1:0]             src_i,
  input  logic [2*NSTAGES-1:0]         prod_we_i,
  input  logic [2*NSTAGES*REG_W-1:0]   prod_rd_i,
  input  logic [1:0]                   ex_load_i,
  output logic [SEL_W-1:0]             sel_o,
  output logic                         load_hit_o
);
  import dii_pkg::*;

  // scan oldest to youngest so the youngest match is the last write
  always_comb begin
    sel_o      = '0;
    load_hit_o = 1'b0;
    for (int s = NSTAGES - 1; s >= 0; s--) begin
      for (int p = 0; p < 2; p++) begin
        if (src_en_i && prod_we_i[2*s+p] &&
            prod_rd_i[(2*s+p)*REG_W +: REG_W] == src_i) begin
          sel_o      = SEL_W'(fwd_code(s, p));
          load_hit_o = (s == 0) && ex_load_i[p];
        end
      end
    end
  end
endmodule

// File: rtl/dii_pair_check.sv
module dii_pair_check #(
  parameter int unsigned REG_W = 5
) (
  input  logic             a_valid_i,
  input  logic [REG_W-1:0] a_rd_i,
  input  logic             a_we_i,
  input  logic             a_mem_i,
  input  logic             a_load_hit_i,
  input  logic             b_valid_i,
  input  logic [REG_W-1:0] b_rs1_i,
  input  logic             b_rs1_en_i,
  input  logic [REG_W-1:0] b_rs2_i,
  input  logic             b_rs2_en_i,
  input  logic             b_mem_i,
  input  logic             b_load_hit_i,
  output dii_pkg::issue_e  issue_o,
  output logic             stall_o,
  output logic             struct_o,
  output logic             dep_o
);
  import dii_pkg::*;

  logic both_valid;
  logic raw_b_on_a;

  assign both_valid = a_valid_i && b_valid_i;
  assign raw_b_on_a = a_we_i && ((b_rs1_en_i && b_rs1_i == a_rd_i) ||
                                 (b_rs2_en_i && b_rs2_i == a_rd_i));

  assign stall_o  = a_valid_i && (a_load_hit_i || (b_valid_i && b_load_hit_i));
  assign struct_o = both_valid && a_mem_i && b_mem_i;
  assign dep_o    = both_valid && raw_b_on_a;

  always_comb begin
    if (!a_valid_i || stall_o)          issue_o = ISSUE_NONE;
    else if (!b_valid_i || dep_o || struct_o) issue_o = ISSUE_A;
    else                                issue_o = ISSUE_BOTH;
  end
endmodule

// File: rtl/dual_issue_interlock.sv
module dual_issue_interlock #(
  parameter int unsigned REG_W = 5,
  localparam int unsigned NSTAGES = 3,
  localparam int unsigned NPROD   = 2 * NSTAGES,
  localparam int unsigned SEL_W   = $clog2(NPROD + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             a_valid_i,
  input  logic [REG_W-1:0] a_rs1_i,
  input  logic             a_rs1_en_i,
  input  logic [REG_W-1:0] a_rs2_i,
  input  logic             a_rs2_en_i,
  input  logic [REG_W-1:0] a_rd_i,
  input  logic             a_we_i,
  input  logic             a_mem_i,
  input  logic             b_valid_i,
  input  logic [REG_W-1:0] b_rs1_i,
  input  logic             b_rs1_en_i,
  input  logic [REG_W-1:0] b_rs2_i,
  input  logic             b_rs2_en_i,
  input  logic [REG_W-1:0] b_rd_i,
  input  logic             b_we_i,
  input  logic             b_mem_i,
  input  logic             ex_a_we_i,
  input  logic [REG_W-1:0] ex_a_rd_i,
  input  logic             ex_a_load_i,
  input  logic             ex_b_we_i,
  input  logic [REG_W-1:0] ex_b_rd_i,
  input  logic             ex_b_load_i,
  input  logic             mem_a_we_i,
  input  logic [REG_W-1:0] mem_a_rd_i,
  input  logic             mem_b_we_i,
  input  logic [REG_W-1:0] mem_b_rd_i,
  input  logic             wb_a_we_i,
  input  logic [REG_W-1:0] wb_a_rd_i,
  input  logic             wb_b_we_i,
  input  logic [REG_W-1:0] wb_b_rd_i,
  output logic             issue_a_o,
  output logic             issue_b_o,
  output logic             stall_o,
  output logic             struct_hazard_o,
  output logic             pair_dep_o,
  output logic [SEL_W-1:0] fwd_a1_o,
  output logic [SEL_W-1:0] fwd_a2_o,
  output logic [SEL_W-1:0] fwd_b1_o,
  output logic [SEL_W-1:0] fwd_b2_o
);
  import dii_pkg::*;

  localparam int unsigned NOPS = 4;

  logic [NPROD-1:0]       prod_we;
  logic [NPROD*REG_W-1:0] prod_rd;
  logic [1:0]             ex_load;
  logic [NOPS-1:0]        op_en;
  logic [REG_W-1:0]       op_src [NOPS];
  logic [SEL_W-1:0]       op_sel [NOPS];
  logic [NOPS-1:0]        op_load;
  logic [NOPS-1:0]        op_slot_b;

  // producer order: index 2*stage + pipe, stage 0 = execute
  assign prod_we = {wb_b_we_i, wb_a_we_i, mem_b_we_i, mem_a_we_i, ex_b_we_i, ex_a_we_i};
  assign prod_rd = {wb_b_rd_i, wb_a_rd_i, mem_b_rd_i, mem_a_rd_i, ex_b_rd_i, ex_a_rd_i};
  assign ex_load = {ex_b_we_i && ex_b_load_i, ex_a_we_i && ex_a_load_i};

  assign op_en     = {b_rs2_en_i, b_rs1_en_i, a_rs2_en_i, a_rs1_en_i};
  assign op_src[0] = a_rs1_i;
  assign op_src[1] = a_rs2_i;
  assign op_src[2] = b_rs1_i;
  assign op_src[3] = b_rs2_i;
  assign op_slot_b = 4'b1100;

  for (genvar g = 0; g < NOPS; g++) begin : g_op
    dii_fwd_select #(
      .REG_W  (REG_W),
      .NSTAGES(NSTAGES),
      .SEL_W  (SEL_W)
    ) u_sel (
      .src_en_i  (op_en[g]),
      .src_i     (op_src[g]),
      .prod_we_i (prod_we),
      .prod_rd_i (prod_rd),
      .ex_load_i (ex_load),
      .sel_o     (op_sel[g]),
      .load_hit_o(op_load[g])
    );
  end

  logic    a_load_hit, b_load_hit;
  issue_e  issue_d;
  logic    stall_d, struct_d, dep_d;

  assign a_load_hit = |(op_load & ~op_slot_b);
  assign b_load_hit = |(op_load & op_slot_b);

  dii_pair_check #(.REG_W(REG_W)) u_pair (
    .a_valid_i   (a_valid_i),
    .a_rd_i      (a_rd_i),
    .a_we_i      (a_we_i),
    .a_mem_i     (a_mem_i),
    .a_load_hit_i(a_load_hit),
    .b_valid_i   (b_valid_i),
    .b_rs1_i     (b_rs1_i),
    .b_rs1_en_i  (b_rs1_en_i),
    .b_rs2_i     (b_rs2_i),
    .b_rs2_en_i  (b_rs2_en_i),
    .b_mem_i     (b_mem_i),
    .b_load_hit_i(b_load_hit),
    .issue_o     (issue_d),
    .stall_o     (stall_d),
    .struct_o    (struct_d),
    .dep_o       (dep_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      issue_a_o       <= 1'b0;
      issue_b_o       <= 1'b0;
      stall_o         <= 1'b0;
      struct_hazard_o <= 1'b0;
      pair_dep_o      <= 1'b0;
      fwd_a1_o        <= '0;
      fwd_a2_o        <= '0;
      fwd_b1_o        <= '0;
      fwd_b2_o        <= '0;
    end else begin
      issue_a_o       <= (issue_d != ISSUE_NONE);
      issue_b_o       <= (issue_d == ISSUE_BOTH);
      stall_o         <= stall_d;
      struct_hazard_o <= struct_d;
      pair_dep_o      <= dep_d;
      fwd_a1_o        <= op_sel[0];
      fwd_a2_o        <= op_sel[1];
      fwd_b1_o        <= op_sel[2];
      fwd_b2_o        <= op_sel[3];
    end
  end
endmodule

// File: rtl/dii_checker.sv
module dii_checker #(
  parameter int unsigned REG_W = 5,
  parameter int unsigned SEL_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             a_valid_i,
  input logic [REG_W-1:0] a_rs1_i,
  input logic             a_rs1_en_i,
  input logic [REG_W-1:0] a_rd_i,
  input logic             a_we_i,
  input logic             b_valid_i,
  input logic [REG_W-1:0] b_rs1_i,
  input logic             b_rs1_en_i,
  input logic             ex_b_we_i,
  input logic [REG_W-1:0] ex_b_rd_i,
  input logic             ex_b_load_i,
  input logic             issue_a_o,
  input logic             issue_b_o,
  input logic             stall_o,
  input logic             struct_hazard_o,
  input logic [SEL_W-1:0] fwd_a1_o
);
  AST_B_NEEDS_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_b_o |-> issue_a_o); // R7

  AST_ONE_MEM_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    struct_hazard_o |-> !issue_b_o); // R6

  AST_STALL_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (!issue_a_o && !issue_b_o)); // R4

  AST_PAIR_RAW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_valid_i && b_valid_i && a_we_i && b_rs1_en_i && b_rs1_i == a_rd_i)
      |=> !issue_b_o); // R5

  AST_LOAD_USE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_valid_i && a_rs1_en_i && ex_b_we_i && ex_b_load_i && ex_b_rd_i == a_rs1_i)
      |=> stall_o); // R4

  AST_EXB_YOUNGEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_rs1_en_i && ex_b_we_i && ex_b_rd_i == a_rs1_i) |=> (fwd_a1_o == SEL_W'(2))); // R1
endmodule

bind dual_issue_interlock dii_checker #(.REG_W(REG_W), .SEL_W(SEL_W)) u_chk (.*);

// File: tb/dual_issue_interlock_tb.sv
module dual_issue_interlock_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic          a_valid, a_rs1_en, a_rs2_en, a_we, a_mem;
  logic [RW-1:0] a_rs1, a_rs2, a_rd;
  logic          b_valid, b_rs1_en, b_rs2_en, b_we, b_mem;
  logic [RW-1:0] b_rs1, b_rs2, b_rd;
  logic          pwe [6];
  logic [RW-1:0] prd [6];
  logic          ld [2];

  logic       issue_a, issue_b, stall, structh, pdep;
  logic [2:0] fa1, fa2, fb1, fb2;

  int n_tests = 0;
  int n_fail  = 0;

  dual_issue_interlock dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .a_valid_i(a_valid), .a_rs1_i(a_rs1), .a_rs1_en_i(a_rs1_en), .a_rs2_i(a_rs2),
    .a_rs2_en_i(a_rs2_en), .a_rd_i(a_rd), .a_we_i(a_we), .a_mem_i(a_mem),
    .b_valid_i(b_valid), .b_rs1_i(b_rs1), .b_rs1_en_i(b_rs1_en), .b_rs2_i(b_rs2),
    .b_rs2_en_i(b_rs2_en), .b_rd_i(b_rd), .b_we_i(b_we), .b_mem_i(b_mem),
    .ex_a_we_i(pwe[0]), .ex_a_rd_i(prd[0]), .ex_a_load_i(ld[0]),
    .ex_b_we_i(pwe[1]), .ex_b_rd_i(prd[1]), .ex_b_load_i(ld[1]),
    .mem_a_we_i(pwe[2]), .mem_a_rd_i(prd[2]), .mem_b_we_i(pwe[3]), .mem_b_rd_i(prd[3]),
    .wb_a_we_i(pwe[4]), .wb_a_rd_i(prd[4]), .wb_b_we_i(pwe[5]), .wb_b_rd_i(prd[5]),
    .issue_a_o(issue_a), .issue_b_o(issue_b), .stall_o(stall),
    .struct_hazard_o(structh), .pair_dep_o(pdep),
    .fwd_a1_o(fa1), .fwd_a2_o(fa2), .fwd_b1_o(fb1), .fwd_b2_o(fb2)
  );

  // reference model, built from the requirements
  function automatic int ref_sel(logic en, logic [RW-1:0] src);
    int r = 0;
    for (int s = 2; s >= 0; s--)
      for (int p = 0; p < 2; p++)
        if (en && pwe[2*s+p] && prd[2*s+p] == src) r = 2*s + p + 1;
    return r;
  endfunction

  function automatic logic ref_lh(int sel);
    return (sel == 1 && ld[0]) || (sel == 2 && ld[1]);
  endfunction

  int e_sel [4];
  logic e_stall, e_struct, e_dep, e_ia, e_ib;

  task automatic compute_exp();
    e_sel[0] = ref_sel(a_rs1_en, a_rs1);
    e_sel[1] = ref_sel(a_rs2_en, a_rs2);
    e_sel[2] = ref_sel(b_rs1_en, b_rs1);
    e_sel[3] = ref_sel(b_rs2_en, b_rs2);
    e_stall  = a_valid && (ref_lh(e_sel[0]) || ref_lh(e_sel[1]) ||
               (b_valid && (ref_lh(e_sel[2]) || ref_lh(e_sel[3]))));
    e_struct = a_valid && b_valid && a_mem && b_mem;
    e_dep    = a_valid && b_valid && a_we &&
               ((b_rs1_en && b_rs1 == a_rd) || (b_rs2_en && b_rs2 == a_rd));
    e_ia     = a_valid && !e_stall;
    e_ib     = e_ia && b_valid && !e_dep && !e_struct;
  endtask

  task automatic chk(string req, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_all(string req);
    chk(req, "fwd_a1", int'(fa1), e_sel[0]);
    chk(req, "fwd_a2", int'(fa2), e_sel[1]);
    chk(req, "fwd_b1", int'(fb1), e_sel[2]);
    chk(req, "fwd_b2", int'(fb2), e_sel[3]);
    chk(req, "stall", int'(stall), int'(e_stall));
    chk(req, "struct", int'(structh), int'(e_struct));
    chk(req, "pair_dep", int'(pdep), int'(e_dep));
    chk(req, "issue_a", int'(issue_a), int'(e_ia));
    chk(req, "issue_b", int'(issue_b), int'(e_ib));
  endtask

  task automatic clear_all();
    a_valid = 0; a_rs1_en = 0; a_rs2_en = 0; a_we = 0; a_mem = 0;
    a_rs1 = 0; a_rs2 = 0; a_rd = 0;
    b_valid = 0; b_rs1_en = 0; b_rs2_en = 0; b_we = 0; b_mem = 0;
    b_rs1 = 0; b_rs2 = 0; b_rd = 0;
    for (int i = 0; i < 6; i++) begin pwe[i] = 0; prd[i] = 0; end
    ld[0] = 0; ld[1] = 0;
  endtask

  // inputs set at negedge; registered result checked at the following negedge
  task automatic run_vec(string req);
    compute_exp();
    @(posedge clk);
    @(negedge clk);
    chk_all(req);
  endtask

  task automatic randomize_vec();
    a_valid = ($urandom % 8) != 0;  b_valid = ($urandom % 8) != 0;
    a_rs1 = RW'($urandom % 4); a_rs2 = RW'($urandom % 4); a_rd = RW'($urandom % 4);
    b_rs1 = RW'($urandom % 4); b_rs2 = RW'($urandom % 4); b_rd = RW'($urandom % 4);
    a_rs1_en = $urandom % 2; a_rs2_en = $urandom % 2; a_we = $urandom % 2;
    b_rs1_en = $urandom % 2; b_rs2_en = $urandom % 2; b_we = $urandom % 2;
    a_mem = ($urandom % 3) == 0; b_mem = ($urandom % 3) == 0;
    for (int i = 0; i < 6; i++) begin
      pwe[i] = ($urandom % 3) != 0;
      prd[i] = RW'($urandom % 4);
    end
    ld[0] = ($urandom % 4) == 0; ld[1] = ($urandom % 4) == 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    clear_all();
    a_valid = 1; b_valid = 1; a_rs1_en = 1; pwe[1] = 1;
    repeat (3) @(negedge clk);
    // R9: reset state despite active inputs
    chk("R9", "issue_a", int'(issue_a), 0);
    chk("R9", "issue_b", int'(issue_b), 0);
    chk("R9", "fwd_a1", int'(fa1), 0);
    rst_n = 1'b1;
    clear_all();
    run_vec("R8");               // R8: nothing valid, nothing issues

    // R1: every stage and pipe matches; execute B wins
    clear_all(); a_valid = 1; a_rs1_en = 1; a_rs1 = 7;
    for (int i = 0; i < 6; i++) begin pwe[i] = 1; prd[i] = 7; end
    run_vec("R1");
    // R1: memory B over memory A over writeback
    pwe[0] = 0; pwe[1] = 0; run_vec("R1");
    pwe[3] = 0; run_vec("R1");
    pwe[2] = 0; run_vec("R1");   // writeback B
    pwe[5] = 0; run_vec("R1");   // writeback A
    // R2: no write enable, or source unused
    pwe[4] = 0; run_vec("R2");
    pwe[4] = 1; a_rs1_en = 0; run_vec("R2");

    // R3: register 0 forwarded like any other
    clear_all(); a_valid = 1; a_rs2_en = 1; a_rs2 = 0; pwe[2] = 1; prd[2] = 0;
    run_vec("R3");

    // R4: A reads execute A load -> stall
    clear_all(); a_valid = 1; b_valid = 1; a_rs1_en = 1; a_rs1 = 3;
    pwe[0] = 1; prd[0] = 3; ld[0] = 1;
    run_vec("R4");
    // R4: younger non-load in execute B shadows the load
    pwe[1] = 1; prd[1] = 3; run_vec("R4");
    // R4: B-only load use stalls whole pair
    clear_all(); a_valid = 1; b_valid = 1; b_rs2_en = 1; b_rs2 = 9;
    pwe[1] = 1; prd[1] = 9; ld[1] = 1;
    run_vec("R4");
    b_valid = 0; run_vec("R4");  // invalid B ignored

    // R5: B reads A result, plus memory conflict at the same time
    clear_all(); a_valid = 1; b_valid = 1; a_we = 1; a_rd = 4;
    b_rs2_en = 1; b_rs2 = 4;
    run_vec("R5");
    a_mem = 1; b_mem = 1; run_vec("R6");
    // R5 with load stall on A: nothing issues
    a_rs1_en = 1; a_rs1 = 6; pwe[0] = 1; prd[0] = 6; ld[0] = 1;
    run_vec("R4");
    // R6: memory conflict alone
    clear_all(); a_valid = 1; b_valid = 1; a_mem = 1; b_mem = 1; run_vec("R6");
    b_mem = 0; run_vec("R7");     // clean pair issues both
    a_valid = 0; run_vec("R7");   // B never without A

    for (int k = 0; k < 600; k++) begin
      randomize_vec();
      run_vec("R1");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule